// File: doc/BRIEF.md
# Powered Port Detection Sequencer

This block is the digital control loop for one power-sourcing Ethernet port. It asks an external detection front end for a measurement, and it judges the returned signature code against the selected legacy policy. It then either powers the port or tries again. A failed attempt can be followed by a long backoff when the port sits in a midspan position. The block checks a shared power-budget flag in the cycle it would switch the port on. Once the port is powered, it watches a disconnect-sense flag and a shutdown input and drops power on either.

Detection results arrive as a valid/ready stream. `det_ready` is high only while the sequencer is waiting for a result. A beat is taken in a cycle where both `det_valid` and `det_ready` are high. The front end may hold `det_valid` high for as long as it likes, and nothing it presents while `det_ready` is low has any effect. No more than one result is taken per clock cycle. All long delays count ticks of one prescaler that is derived from the clock frequency. The prescaler restarts whenever a delay is armed, so every delay has an exact length in cycles.

The LED sink output pulls down while the port has power. A single-supply strap turns this steady drive into a short pulse train with a 6% duty cycle. A separate output selects the cut-off current threshold from the class that was latched at turn-on.

Top module: `pse_port_seq`

## Requirements
- R1: While reset is active and directly after it, `pwr_en`, `det_ready` and `led_sink` are 0 and `ilim_sel` is 2'b00.
- R2: After reset is released, or after `shutdown` falls, `det_ready` stays 0 for HOLDOFF_TICKS*CLK_PER_TICK cycles (plus up to 2 pipeline cycles). It is 1 after that.
- R3: While `shutdown` is 1, `pwr_en` and `det_ready` are 0 from the next cycle onward. This also turns off a port that has power.
- R4: A result is taken only in a cycle with `det_valid`=1 and `det_ready`=1. `det_valid` with `det_ready`=0 changes nothing.
- R5: `det_code` encodes 2'b00 valid, 2'b01 open, 2'b10 invalid, 2'b11 large-capacitance legacy. `legacy_mode` 2'b00 (and 2'b11) accepts only valid. 2'b01 accepts valid and legacy. 2'b10 (force power) accepts every code except open. An accepted result with `budget_busy`=0 sets `pwr_en` in the next cycle.
- R6: After an open result, or after any rejected result with `midspan_en`=0, `det_ready` is 1 in the very next cycle.
- R7: After a rejected non-open result with `midspan_en`=1, `det_ready` stays 0 for BACKOFF_TICKS*CLK_PER_TICK cycles (plus 1). It then returns to 1.
- R8: An acceptable result that arrives while `budget_busy`=1 does not power the port. It is treated as a failed non-open attempt.
- R9: With `single_supply`=0, `led_sink` equals `pwr_en`.
- R10: With `single_supply`=1 and the port powered, `led_sink` is 1 for exactly LED_ON_CYC of every LED_PERIOD consecutive cycles. The defaults are 3 of 50, which gives 6%. It is 0 while the port is unpowered.
- R11: `ilim_sel` is 2'b01 for latched class 1 and 2'b10 for latched class 2, but only while the port is powered and `enforce_class`=1. In every other case it is 2'b00, the default 375 mA threshold. The class is taken from `cls_code` in the cycle the result is accepted.
- R12: With the port powered, `disc_sense` held at 1 for MPS_TICKS*CLK_PER_TICK cycles removes power and returns the block to detection. A shorter high pulse leaves power on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Inhibits detection and power when 1 |
| midspan_en | input | 1 | Enables backoff after failed non-open attempts |
| legacy_mode | input | 2 | Acceptance policy: 00 compliant, 01 legacy, 10 force power |
| enforce_class | input | 1 | Enables reduced thresholds for class 1 and 2 |
| single_supply | input | 1 | Selects pulsed LED drive |
| budget_busy | input | 1 | Shared budget exhausted; blocks turn-on |
| disc_sense | input | 1 | Low-capacitance / no-device indication |
| det_valid | input | 1 | Detection result valid |
| det_ready | output | 1 | Sequencer waiting for a result (detect request) |
| det_code | input | 2 | Detection result code |
| cls_code | input | 3 | Measured class of the device |
| pwr_en | output | 1 | Port power switch enable |
| ilim_sel | output | 2 | Cut-off threshold select code |
| led_sink | output | 1 | LED pull-down drive |

## Verification
The hardest situations to reach are the timing edges around disconnect and backoff. These are a disconnect pulse one prescaler run too short to drop power, and a result offered while the sequencer is still in its restart holdoff. The bench shortens every tick to four cycles. It then places `disc_sense` pulses a few cycles under and over the timeout, and measures the backoff and holdoff windows in cycles. It also strobes `det_valid` during holdoff and during shutdown, and it proves at the power and ready outputs that those beats left no trace.

// File: rtl/pse_port_seq_pkg.sv
package pse_port_seq_pkg;

  typedef enum logic [2:0] {
    ST_SHUT  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_DET   = 3'd2,
    ST_BACK  = 3'd3,
    ST_PWR   = 3'd4
  } seq_state_e;

  localparam logic [1:0] DET_VALID   = 2'b00;
  localparam logic [1:0] DET_OPEN    = 2'b01;
  localparam logic [1:0] DET_INVALID = 2'b10;
  localparam logic [1:0] DET_LEGACY  = 2'b11;

  localparam logic [1:0] LM_COMPLIANT = 2'b00;
  localparam logic [1:0] LM_LEGACY    = 2'b01;
  localparam logic [1:0] LM_FORCE     = 2'b10;

  localparam logic [1:0] ILIM_DEFAULT = 2'b00;
  localparam logic [1:0] ILIM_CLASS1  = 2'b01;
  localparam logic [1:0] ILIM_CLASS2  = 2'b10;

  function automatic logic sig_acceptable(input logic [1:0] mode, input logic [1:0] code);
    logic ok;
    case (mode)
      LM_LEGACY: ok = (code == DET_VALID) || (code == DET_LEGACY);
      LM_FORCE:  ok = (code != DET_OPEN);
      default:   ok = (code == DET_VALID);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pse_tick_timer.sv
module pse_tick_timer #(
  parameter int CLK_PER_TICK = 4,
  parameter int CW           = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PW-1:0] PLAST = PW'(CLK_PER_TICK - 1);

  logic [PW-1:0] presc_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      presc_q <= '0;
      cnt_q   <= load_val;
    end else if (cnt_q != '0) begin
      if (presc_q == PLAST) begin
        presc_q <= '0;
        cnt_q   <= cnt_q - 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pse_led_drive.sv
module pse_led_drive #(
  parameter int LED_PERIOD = 50,
  parameter int LED_ON_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lit,
  input  logic pulsed,
  output logic sink
);
  localparam int LW = (LED_PERIOD > 1) ? $clog2(LED_PERIOD) : 1;
  localparam logic [LW-1:0] LLAST = LW'(LED_PERIOD - 1);
  localparam logic [LW-1:0] LON   = LW'(LED_ON_CYC);

  logic [LW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (phase_q == LLAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign sink = lit && (!pulsed || (phase_q < LON));
endmodule

// File: rtl/pse_ilim_select.sv
module pse_ilim_select
  import pse_port_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [2:0] cls_in,
  input  logic       powered,
  input  logic       enforce,
  output logic [1:0] sel
);
  logic [2:0] cls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cls_q <= '0;
    else if (capture) cls_q <= cls_in;
  end

  always_comb begin
    sel = ILIM_DEFAULT;
    if (powered && enforce) begin
      if (cls_q == 3'd1)      sel = ILIM_CLASS1;
      else if (cls_q == 3'd2) sel = ILIM_CLASS2;
    end
  end
endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
  import pse_port_seq_pkg::*;
#(
  parameter int CLK_HZ        = 100_000_000,
  parameter int TICK_HZ       = 10,
  parameter int HOLDOFF_TICKS = 40,
  parameter int BACKOFF_TICKS = 32,
  parameter int MPS_TICKS     = 4,
  parameter int LED_PERIOD    = 50,
  parameter int LED_ON_CYC    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shutdown,
  input  logic       midspan_en,
  input  logic [1:0] legacy_mode,
  input  logic       enforce_class,
  input  logic       single_supply,
  input  logic       budget_busy,
  input  logic       disc_sense,
  input  logic       det_valid,
  output logic       det_ready,
  input  logic [1:0] det_code,
  input  logic [2:0] cls_code,
  output logic       pwr_en,
  output logic [1:0] ilim_sel,
  output logic       led_sink
);
  localparam int CLK_PER_TICK = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
  localparam int MAX_A = (HOLDOFF_TICKS > BACKOFF_TICKS) ? HOLDOFF_TICKS : BACKOFF_TICKS;
  localparam int MAX_T = (MAX_A > MPS_TICKS) ? MAX_A : MPS_TICKS;
  localparam int TCW   = $clog2(MAX_T + 1);

  seq_state_e   st_q, st_d;
  logic         tmr_load, tmr_done, take_cls;
  logic [TCW-1:0] tmr_val;
  logic         take, good;

  assign take = det_valid && (st_q == ST_DET);
  assign good = sig_acceptable(legacy_mode, det_code) && !budget_busy;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take_cls = 1'b0;
    if (shutdown) begin
      st_d = ST_SHUT;
    end else begin
      case (st_q)
        ST_SHUT: begin
          st_d     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = TCW'(HOLDOFF_TICKS);
        end
        ST_HOLD: if (tmr_done) st_d = ST_DET;
        ST_DET: begin
          if (take) begin
            if (good) begin
              st_d     = ST_PWR;
              tmr_load = 1'b1;
              tmr_val  = TCW'(MPS_TICKS);
              take_cls = 1'b1;
            end else if (midspan_en && det_code != DET_OPEN) begin
              st_d     = ST_BACK;
              tmr_load = 1'b1;
              tmr_val  = TCW'(BACKOFF_TICKS);
            end
          end
        end
        ST_BACK: if (tmr_done) st_d = ST_DET;
        ST_PWR: begin
          if (!disc_sense) begin
            tmr_load = 1'b1;
            tmr_val  = TCW'(MPS_TICKS);
          end else if (tmr_done) begin
            st_d = ST_DET;
          end
        end
        default: st_d = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SHUT;
    else        st_q <= st_d;
  end

  assign det_ready = (st_q == ST_DET);
  assign pwr_en    = (st_q == ST_PWR);

  pse_tick_timer #(.CLK_PER_TICK(CLK_PER_TICK), .CW(TCW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  pse_ilim_select u_ilim (
    .clk(clk), .rst_n(rst_n), .capture(take_cls), .cls_in(cls_code),
    .powered(pwr_en), .enforce(enforce_class), .sel(ilim_sel)
  );

  pse_led_drive #(.LED_PERIOD(LED_PERIOD), .LED_ON_CYC(LED_ON_CYC)) u_led (
    .clk(clk), .rst_n(rst_n), .lit(pwr_en), .pulsed(single_supply), .sink(led_sink)
  );
endmodule

// File: rtl/pse_port_seq_chk.sv
module pse_port_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       shutdown,
  input logic       midspan_en,
  input logic [1:0] legacy_mode,
  input logic       enforce_class,
  input logic       budget_busy,
  input logic       disc_sense,
  input logic       det_valid,
  input logic       det_ready,
  input logic [1:0] det_code,
  input logic       pwr_en,
  input logic [1:0] ilim_sel,
  input logic       led_sink,
  input logic       single_supply
);
  a_r3_shutdown_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!pwr_en && !det_ready));

  a_r4_ready_excludes_power: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_ready && pwr_en));

  a_r5_compliant_rejects_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_ready && legacy_mode == 2'b00 && det_code == 2'b11) |=> !pwr_en);

  a_r6_open_retries: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_ready && det_code == 2'b01 && !shutdown) |=> det_ready);

  a_r7_backoff_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_ready && midspan_en && det_code == 2'b10) |=> !det_ready);

  a_r8_budget_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_ready && budget_busy) |=> !pwr_en);

  a_r9_led_dark_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !led_sink);

  a_r11_default_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enforce_class || !pwr_en) |-> (ilim_sel == 2'b00));

  a_r12_drop_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(shutdown) || $past(disc_sense)));
endmodule

bind pse_port_seq pse_port_seq_chk u_chk (.*);

// File: tb/pse_port_seq_test.sv
module pse_port_seq_test;
  localparam int CPT  = 4;
  localparam int HOLD = 10;
  localparam int BACK = 8;
  localparam int MPS  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shutdown = 0, midspan_en = 0, enforce_class = 0, single_supply = 0;
  logic budget_busy = 0, disc_sense = 0, det_valid = 0;
  logic [1:0] legacy_mode = 2'b00, det_code = 2'b00;
  logic [2:0] cls_code = 3'd0;
  logic det_ready, pwr_en, led_sink;
  logic [1:0] ilim_sel;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  pse_port_seq #(.CLK_HZ(400), .TICK_HZ(100), .HOLDOFF_TICKS(HOLD),
                 .BACKOFF_TICKS(BACK), .MPS_TICKS(MPS)) uut (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .midspan_en(midspan_en),
    .legacy_mode(legacy_mode), .enforce_class(enforce_class),
    .single_supply(single_supply), .budget_busy(budget_busy),
    .disc_sense(disc_sense), .det_valid(det_valid), .det_ready(det_ready),
    .det_code(det_code), .cls_code(cls_code), .pwr_en(pwr_en),
    .ilim_sel(ilim_sel), .led_sink(led_sink));

  // {legacy_mode, det_code, budget_busy, expected power}
  localparam logic [5:0] VEC [13] = '{
    {2'b00, 2'b00, 1'b0, 1'b1}, {2'b00, 2'b11, 1'b0, 1'b0},
    {2'b00, 2'b10, 1'b0, 1'b0}, {2'b00, 2'b01, 1'b0, 1'b0},
    {2'b01, 2'b11, 1'b0, 1'b1}, {2'b01, 2'b10, 1'b0, 1'b0},
    {2'b01, 2'b00, 1'b0, 1'b1}, {2'b10, 2'b10, 1'b0, 1'b1},
    {2'b10, 2'b11, 1'b0, 1'b1}, {2'b10, 2'b01, 1'b0, 1'b0},
    {2'b10, 2'b00, 1'b1, 1'b0}, {2'b01, 2'b11, 1'b1, 1'b0},
    {2'b11, 2'b11, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] code);
    det_code = code; det_valid = 1'b1;
    @(negedge clk);
    det_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!det_ready && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic restart();
    int n;
    shutdown = 1'b1; step(1); shutdown = 1'b0;
    wait_ready(n);
  endtask

  task automatic power_up(input logic [2:0] cls);
    legacy_mode = 2'b00; budget_busy = 1'b0; cls_code = cls;
    send(2'b00);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, cnt;
    // R1: reset state
    step(3);
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 det_ready", det_ready, 0);
    chk("R1 led_sink", led_sink, 0);
    chk("R1 ilim_sel", ilim_sel, 0);
    rst_n = 1'b1;
    // R2: restart holdoff measured from reset release
    wait_ready(n);
    checks++;
    if (n < HOLD*CPT || n > HOLD*CPT + 4) begin
      fails++; $display("FAIL R2 holdoff: actual %0d expected %0d..%0d", n, HOLD*CPT, HOLD*CPT+4);
    end

    // R5/R6/R8: acceptance table
    foreach (VEC[i]) begin
      legacy_mode = VEC[i][5:4]; budget_busy = VEC[i][1];
      send(VEC[i][3:2]);
      chk($sformatf("R5 vec%0d pwr_en", i), pwr_en, VEC[i][0]);
      if (VEC[i][0]) begin
        chk("R9 led steady on", led_sink, 1);
        restart();
      end else begin
        chk(VEC[i][1] ? "R8 busy retry ready" : "R6 retry ready", det_ready, 1);
        chk("R9 led off", led_sink, 0);
      end
    end
    budget_busy = 1'b0;

    // R7: midspan backoff for invalid, none for open
    midspan_en = 1'b1; legacy_mode = 2'b00;
    send(2'b01);
    chk("R6 open skips backoff", det_ready, 1);
    send(2'b10);
    wait_ready(n);
    checks++;
    if (n < BACK*CPT - 1 || n > BACK*CPT + 3) begin
      fails++; $display("FAIL R7 backoff: actual %0d expected %0d..%0d", n, BACK*CPT-1, BACK*CPT+3);
    end
    midspan_en = 1'b0;

    // R9/R10: LED drive modes
    power_up(3'd0);
    cnt = 0;
    for (int k = 0; k < 50; k++) begin step(1); cnt += led_sink; end
    chk("R9 steady led count", cnt, 50);
    single_supply = 1'b1;
    cnt = 0;
    for (int k = 0; k < 50; k++) begin step(1); cnt += led_sink; end
    chk("R10 pulsed led count", cnt, 3);
    single_supply = 1'b0;
    restart();

    // R11: threshold select
    enforce_class = 1'b1; power_up(3'd1);
    chk("R11 class1 reduced", ilim_sel, 1);
    enforce_class = 1'b0; step(1);
    chk("R11 enforce off default", ilim_sel, 0);
    restart();
    enforce_class = 1'b1; power_up(3'd2);
    chk("R11 class2 reduced", ilim_sel, 2);
    restart();
    power_up(3'd3);
    chk("R11 class3 default", ilim_sel, 0);

    // R12: disconnect timeout
    disc_sense = 1'b1; step(MPS*CPT - 6); disc_sense = 1'b0; step(2);
    chk("R12 short pulse keeps power", pwr_en, 1);
    disc_sense = 1'b1; n = 0;
    while (pwr_en && n < 1000) begin step(1); n++; end
    disc_sense = 1'b0;
    checks++;
    if (n < MPS*CPT - 2 || n > MPS*CPT + 2) begin
      fails++; $display("FAIL R12 timeout: actual %0d expected %0d..%0d", n, MPS*CPT-2, MPS*CPT+2);
    end
    chk("R12 back to detect", det_ready, 1);

    // R3/R4: shutdown while powered, strobes ignored
    power_up(3'd0);
    chk("R3 powered before shutdown", pwr_en, 1);
    shutdown = 1'b1; step(1);
    chk("R3 shutdown drops power", pwr_en, 0);
    chk("R3 shutdown no detect", det_ready, 0);
    send(2'b00); step(2);
    chk("R4 strobe in shutdown ignored", pwr_en, 0);
    shutdown = 1'b0; step(3);
    send(2'b00);
    chk("R4 strobe in holdoff ignored", pwr_en, 0);
    chk("R2 still in holdoff", det_ready, 0);
    wait_ready(n);
    chk("R4 ready after holdoff", det_ready, 1);
    chk("R4 no stale power", pwr_en, 0);

    finish_run();
  end
endmodule